// File: doc/BRIEF.md
# Programmable Tap Delay Controller

This block holds the control logic and a behavioural model of a 64-position delay line. The line is a chain of registers clocked by `clk`. The output is the chain stage picked by the current tap count, together with that count. The block's behaviour for one instance is fixed by elaboration parameters:

- **Mode.** The mode decides how the tap count evolves. It can be:
  - a bypass mode that always uses the shortest path;
  - a fixed mode that holds a preset tap;
  - a variable mode, where increment and decrement requests move the tap at run time.
- **Chain input.** A source parameter picks what drives the chain:
  - the pad-side receive data;
  - the core-side transmit data;
  - a bidirectional arrangement in which a tristate control chooses between the receive and transmit data;
  - a general fabric data input.

Whenever the transmit data feeds the chain, the delay uses a separate, constant transmit tap. It does not use the run-time tap count.

In use, the tap count comes up at a configured initial value. In variable mode, logic around the block then nudges the count one step per clock with the enable and direction inputs. A dedicated tap reset returns the count to the initial value at any time.

Top module: `tap_delay_ctrl`

## Requirements
- R1: On a clock edge with `rst_n` low, `tap_value` becomes `INIT_TAP` in fixed and variable modes and 0 in bypass mode, and every chain stage clears, so `dly_out` reads 0.
- R2: In bypass mode, `tap_value` stays 0 and the receive-path delay is one register stage, whatever `ce`, `inc` and `tap_rst` do.
- R3: In fixed mode, `tap_value` equals `INIT_TAP` on every cycle, and `ce`, `inc` and `tap_rst` have no effect on it.
- R4: In variable mode, a clock edge with `ce`=1 and `tap_rst`=0 raises `tap_value` by one when `inc`=1 and lowers it by one when `inc`=0.
- R5: In variable mode, a clock edge with `ce`=0 and `tap_rst`=0 leaves `tap_value` unchanged.
- R6: The tap count is 6 bits wide and steps modulo 64: one increment from 63 gives 0, and one decrement from 0 gives 63.
- R7: In variable mode, a clock edge with `tap_rst`=1 loads `INIT_TAP` into the count, whatever `ce` and `inc` are.
- R8: After a clock edge, `dly_out` equals the chain input that was sampled N edges earlier, where N is the effective tap. With N=0 the input therefore appears after one register stage.
- R9: The source parameter routes one input into the chain. `SRC_PIN` selects `pin_in`, `SRC_OUT` selects `out_in`, and `SRC_FABRIC` selects `fab_in`.
- R10: With `SRC_BIDIR`, the chain takes `pin_in` while `tri_t`=1 (receive) and `out_in` while `tri_t`=0 (drive).
- R11: Whenever `out_in` feeds the chain, the effective tap is the constant `OUT_TAP`. Otherwise it is `tap_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control and chain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tap_rst | input | 1 | Reload the tap count with its initial value |
| ce | input | 1 | Tap step enable (variable mode) |
| inc | input | 1 | Step direction: 1 up, 0 down |
| pin_in | input | 1 | Pad-side receive data |
| out_in | input | 1 | Core-side transmit data |
| fab_in | input | 1 | General fabric data |
| tri_t | input | 1 | Tristate control: 1 receive, 0 drive |
| dly_out | output | 1 | Delayed chain output |
| tap_value | output | 6 | Current receive-path tap count |

## Verification
The bench goes after the following corner cases:

- **Wrap at both ends of the tap range.** A counter that saturates instead of wrapping would read 63 or 0 where 0 or 63 is expected.
- **Tap reset combined with an active step request.** Giving the step priority would leave the count one away from its initial value.
- **Bypass and fixed instances under a storm of step and reset requests.** Logic that leaks the controls would move their taps.
- **Bidirectional source with `tri_t` toggling every cycle.** Tapping the wrong stage, or using the run-time tap for transmit data, shows up as a mismatch against a history of the inputs sampled at each edge.
- **Zero-tap path.** An output taken straight from the input instead of one register deep would be one cycle early.

// File: rtl/tdc_pkg.sv
// Shared mode and source encodings for the tap delay controller.
package tdc_pkg;
    // How the tap count evolves.
    typedef enum logic [1:0] {
        MODE_BYPASS   = 2'd0,
        MODE_FIXED    = 2'd1,
        MODE_VARIABLE = 2'd2
    } dly_mode_e;

    // What drives the delay chain.
    typedef enum logic [1:0] {
        SRC_PIN    = 2'd0,
        SRC_OUT    = 2'd1,
        SRC_BIDIR  = 2'd2,
        SRC_FABRIC = 2'd3
    } dly_src_e;
endpackage

// File: rtl/tdc_src_sel.sv
// Chain source selector.
// Picks the chain input according to the SRC parameter. It also flags when the
// transmit data is chosen, so that the top can apply the fixed transmit tap.
// Assumes: tri_t = 1 means receive, tri_t = 0 means drive.
module tdc_src_sel
    import tdc_pkg::*;
#(
    parameter dly_src_e SRC = SRC_BIDIR
) (
    input  logic pin_in,
    input  logic out_in,
    input  logic fab_in,
    input  logic tri_t,
    output logic sel_data,
    output logic use_out
);
    // Static source choice, with the bidirectional case steered by tri_t.
    always_comb begin
        sel_data = 1'b0;
        use_out  = 1'b0;
        case (SRC)
            SRC_PIN:    sel_data = pin_in;
            SRC_OUT: begin
                sel_data = out_in;
                use_out  = 1'b1;
            end
            SRC_BIDIR: begin
                sel_data = tri_t ? pin_in : out_in;
                use_out  = ~tri_t;
            end
            default:    sel_data = fab_in;
        endcase
    end
endmodule

// File: rtl/tdc_tap_ctrl.sv
// Tap count register.
// Applies the mode-dependent update policy.
// Assumes: INIT_TAP < 2**TAP_W; synchronous active-low reset.
module tdc_tap_ctrl
    import tdc_pkg::*;
#(
    parameter dly_mode_e MODE     = MODE_VARIABLE,
    parameter int        TAP_W    = 6,
    parameter int        INIT_TAP = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tap_rst,
    input  logic             ce,
    input  logic             inc,
    output logic [TAP_W-1:0] tap_q
);
    localparam logic [TAP_W-1:0] INIT_V = TAP_W'(INIT_TAP);
    localparam logic [TAP_W-1:0] RST_V  = (MODE == MODE_BYPASS) ? '0 : INIT_V;

    logic [TAP_W-1:0] tap_nxt;

    // Next tap according to mode; step arithmetic wraps modulo 2**TAP_W.
    always_comb begin
        tap_nxt = tap_q;
        case (MODE)
            MODE_BYPASS: tap_nxt = '0;
            MODE_FIXED:  tap_nxt = INIT_V;
            default: begin
                if (tap_rst)
                    tap_nxt = INIT_V;
                else if (ce)
                    tap_nxt = inc ? tap_q + 1'b1 : tap_q - 1'b1;
            end
        endcase
    end

    // Tap register with synchronous reset to the mode's start value.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= RST_V;
        else        tap_q <= tap_nxt;
    end

    generate
        if (MODE == MODE_VARIABLE) begin : g_var_chk
            assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (ce && inc && !tap_rst) |=> (tap_q == $past(tap_q) + 1'b1));
            assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (ce && !inc && !tap_rst) |=> (tap_q == $past(tap_q) - 1'b1));
            assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!ce && !tap_rst) |=> (tap_q == $past(tap_q)));
            assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
                tap_rst |=> (tap_q == INIT_V));
        end else if (MODE == MODE_FIXED) begin : g_fix_chk
            assert_fixed_tap_R3: assert property (@(posedge clk) disable iff (!rst_n)
                ce |=> (tap_q == INIT_V));
        end else begin : g_byp_chk
            assert_bypass_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (ce || tap_rst) |=> (tap_q == '0));
        end
    endgenerate
endmodule

// File: rtl/tdc_chain.sv
// Delay chain model.
// A STAGES-deep register chain with a tap multiplexer on the output.
// Stage k holds the input sampled k+1 edges ago.
// Assumes: sel < STAGES; synchronous active-low reset clears all stages.
module tdc_chain #(
    parameter int STAGES = 64,
    parameter int SEL_W  = $clog2(STAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             dout
);
    logic [STAGES-1:0] stage_q;
    logic              up_q;

    // Shift the new sample in at stage 0.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], din};
    end

    // Marks that at least one edge has passed out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    // Tap multiplexer.
    assign dout = stage_q[sel];

    assert_zero_tap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && sel == '0) |-> (dout == $past(din)));
endmodule

// File: rtl/tap_delay_ctrl.sv
// Programmable tap delay controller, top level.
// Joins the source selector, the tap counter and the delay chain. The receive
// path uses the run-time tap count; transmit data uses the constant OUT_TAP.
// Assumes: INIT_TAP and OUT_TAP lie in 0 .. TAPS-1.
module tap_delay_ctrl
    import tdc_pkg::*;
#(
    parameter dly_mode_e MODE     = MODE_VARIABLE,
    parameter dly_src_e  SRC      = SRC_BIDIR,
    parameter int        TAPS     = 64,
    parameter int        INIT_TAP = 0,
    parameter int        OUT_TAP  = 0,
    localparam int       TAP_W    = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tap_rst,
    input  logic             ce,
    input  logic             inc,
    input  logic             pin_in,
    input  logic             out_in,
    input  logic             fab_in,
    input  logic             tri_t,
    output logic             dly_out,
    output logic [TAP_W-1:0] tap_value
);
    localparam logic [TAP_W-1:0] OUT_V = TAP_W'(OUT_TAP);

    logic             sel_data;
    logic             use_out;
    logic [TAP_W-1:0] eff_tap;

    tdc_src_sel #(.SRC(SRC)) u_src (
        .pin_in  (pin_in),
        .out_in  (out_in),
        .fab_in  (fab_in),
        .tri_t   (tri_t),
        .sel_data(sel_data),
        .use_out (use_out)
    );

    tdc_tap_ctrl #(.MODE(MODE), .TAP_W(TAP_W), .INIT_TAP(INIT_TAP)) u_tap (
        .clk    (clk),
        .rst_n  (rst_n),
        .tap_rst(tap_rst),
        .ce     (ce),
        .inc    (inc),
        .tap_q  (tap_value)
    );

    // Transmit data takes the constant transmit tap, receive data the live count.
    assign eff_tap = use_out ? OUT_V : tap_value;

    tdc_chain #(.STAGES(TAPS), .SEL_W(TAP_W)) u_chain (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sel_data),
        .sel  (eff_tap),
        .dout (dly_out)
    );

    assert_reset_tap_R1: assert property (@(posedge clk)
        !rst_n |=> (tap_value == ((MODE == MODE_BYPASS) ? '0 : TAP_W'(INIT_TAP))));
    assert_reset_out_R1: assert property (@(posedge clk)
        !rst_n |=> (dly_out == 1'b0));
endmodule

// File: tb/sim_tap_delay_ctrl.sv
// Directed bench. Four instances share one set of stimulus:
//   u0 variable/bidir (init 5, tx tap 9)
//   u1 fixed/pin (init 12)
//   u2 bypass/fabric
//   u3 variable/out (init 0, tx tap 3)
module sim_tap_delay_ctrl;
    import tdc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tap_rst = 1'b0, ce = 1'b0, inc = 1'b0;
    logic pin_in = 1'b0, out_in = 1'b0, fab_in = 1'b0, tri_t = 1'b1;
    logic       d0, d1, d2, d3;
    logic [5:0] t0, t1, t2, t3;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tap_delay_ctrl #(.MODE(MODE_VARIABLE), .SRC(SRC_BIDIR), .INIT_TAP(5), .OUT_TAP(9)) u0 (
        .clk(clk), .rst_n(rst_n), .tap_rst(tap_rst), .ce(ce), .inc(inc), .pin_in(pin_in),
        .out_in(out_in), .fab_in(fab_in), .tri_t(tri_t), .dly_out(d0), .tap_value(t0));
    tap_delay_ctrl #(.MODE(MODE_FIXED), .SRC(SRC_PIN), .INIT_TAP(12), .OUT_TAP(0)) u1 (
        .clk(clk), .rst_n(rst_n), .tap_rst(tap_rst), .ce(ce), .inc(inc), .pin_in(pin_in),
        .out_in(out_in), .fab_in(fab_in), .tri_t(tri_t), .dly_out(d1), .tap_value(t1));
    tap_delay_ctrl #(.MODE(MODE_BYPASS), .SRC(SRC_FABRIC), .INIT_TAP(7), .OUT_TAP(0)) u2 (
        .clk(clk), .rst_n(rst_n), .tap_rst(tap_rst), .ce(ce), .inc(inc), .pin_in(pin_in),
        .out_in(out_in), .fab_in(fab_in), .tri_t(tri_t), .dly_out(d2), .tap_value(t2));
    tap_delay_ctrl #(.MODE(MODE_VARIABLE), .SRC(SRC_OUT), .INIT_TAP(0), .OUT_TAP(3)) u3 (
        .clk(clk), .rst_n(rst_n), .tap_rst(tap_rst), .ce(ce), .inc(inc), .pin_in(pin_in),
        .out_in(out_in), .fab_in(fab_in), .tri_t(tri_t), .dly_out(d3), .tap_value(t3));

    // Reference: expected taps of the variable instances, and the input history per source.
    logic [5:0]  e0, e3;
    logic [63:0] h0, h1, h2, h3;
    always @(posedge clk) begin
        if (!rst_n || tap_rst) begin
            e0 <= 6'd5;
            e3 <= 6'd0;
        end else if (ce) begin
            e0 <= inc ? e0 + 6'd1 : e0 - 6'd1;
            e3 <= inc ? e3 + 6'd1 : e3 - 6'd1;
        end
        if (!rst_n) begin
            h0 <= '0; h1 <= '0; h2 <= '0; h3 <= '0;
        end else begin
            h0 <= {h0[62:0], tri_t ? pin_in : out_in};
            h1 <= {h1[62:0], pin_in};
            h2 <= {h2[62:0], fab_in};
            h3 <= {h3[62:0], out_in};
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: compare every output at the negedge, then drive fresh data.
    task automatic tick(input string tag);
        @(negedge clk);
        if (rst_n) begin
            chk(tag, "u0 tap", t0, e0);
            chk(tag, "u1 tap (R3)", t1, 12);
            chk(tag, "u2 tap (R2)", t2, 0);
            chk(tag, "u3 tap", t3, e3);
            chk(tag, "u0 out (R10,R11)", d0, h0[tri_t ? e0 : 6'd9]);
            chk(tag, "u1 out (R9)", d1, h1[12]);
            chk(tag, "u2 out (R2,R9)", d2, h2[0]);
            chk(tag, "u3 out (R11)", d3, h3[3]);
        end
        pin_in = 1'($urandom);
        out_in = 1'($urandom);
        fab_in = 1'($urandom);
    endtask

    task automatic t_reset_r1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "u0 tap in reset", t0, 5);
        chk("R1", "u1 tap in reset", t1, 12);
        chk("R1", "u2 tap in reset", t2, 0);
        chk("R1", "u3 tap in reset", t3, 0);
        chk("R1", "outputs in reset", {d0, d1, d2, d3}, 0);
        rst_n = 1'b1;
        repeat (70) tick("R1");
    endtask

    task automatic t_step_r4;
        ce = 1'b1; inc = 1'b1; tri_t = 1'b1;
        repeat (10) tick("R4");
        chk("R4", "u0 after 10 up", t0, 15);
        inc = 1'b0;
        repeat (4) tick("R4");
        chk("R4", "u0 after 4 down", t0, 11);
        ce = 1'b0;
    endtask

    task automatic t_hold_r5;
        ce = 1'b0; inc = 1'b1;
        repeat (8) begin
            tick("R5");
            inc = ~inc;
        end
        chk("R5", "u0 held", t0, 11);
    endtask

    task automatic t_wrap_r6;
        tap_rst = 1'b1;
        tick("R6");
        tap_rst = 1'b0; ce = 1'b1; inc = 1'b0;
        tick("R6");
        ce = 1'b0;
        tick("R6");
        chk("R6", "u3 0 minus 1", t3, 63);
        chk("R6", "u0 5 minus 1", t0, 4);
        ce = 1'b1; inc = 1'b1;
        repeat (60) tick("R6");
        ce = 1'b0;
        tick("R6");
        chk("R6", "u0 63 plus 1", t0, 0);
    endtask

    task automatic t_reload_r7;
        ce = 1'b1; inc = 1'b1;
        repeat (6) tick("R7");
        tap_rst = 1'b1;
        tick("R7");
        tap_rst = 1'b0; ce = 1'b0;
        tick("R7");
        chk("R7", "u0 reload beats step", t0, 5);
        chk("R7", "u3 reload beats step", t3, 0);
    endtask

    task automatic t_static_r3;
        repeat (20) begin
            ce = 1'($urandom); inc = 1'($urandom); tap_rst = 1'($urandom);
            tick("R3");
        end
        ce = 1'b0; tap_rst = 1'b0;
        tick("R3");
        chk("R3", "u1 fixed tap", t1, 12);
        chk("R2", "u2 bypass tap", t2, 0);
    endtask

    task automatic t_path_r8;
        tap_rst = 1'b1;
        tick("R8");
        tap_rst = 1'b0; ce = 1'b1; inc = 1'b0;
        repeat (5) tick("R8");
        ce = 1'b0;
        repeat (80) begin
            tri_t = 1'($urandom);
            tick("R10");
        end
        tri_t = 1'b1;
        repeat (3) tick("R8");
        chk("R8", "u0 zero tap", t0, 0);
        @(negedge clk);
        chk("R8", "u0 one-stage path", d0, h0[0]);
    endtask

    initial begin
        t_reset_r1();
        t_step_r4();
        t_hold_r5();
        t_wrap_r6();
        t_reload_r7();
        t_static_r3();
        t_path_r8();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule